// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits beside a flash array controller. It watches the write cycles that a host sends to the flash region and recognises multi-cycle command sequences. A sequence opens with two unlock writes, each a fixed address/data pair, and then a command byte follows. The decoder recognises these sequences: word program, whole-array erase, sector erase (with a window that gathers more sectors), erase suspend and resume, identifier/protection read, and an unlock-bypass mode in which program commands skip the unlock writes. It does not time the array and does not run the embedded algorithms. When a complete command is recognised, it presents a command record to the array engine. It then reports busy until the engine pulses `op_done`.

Host writes arrive on a valid/ready stream. A write is taken on a clock edge where `wr_valid` and `wr_ready` are both high. Decoded commands leave on a second valid/ready stream. A record is held with all its fields stable until `cmd_ready` is sampled high. While a record waits, `wr_ready` stays low, so the host is back-pressured and no write can reach a decoder that has not yet handed off its last command. `id_sel` tells the read path whether to return array data or `id_data`. A gap counter aborts partial sequences that stall.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A sequence opens only with data AAh to an address whose bits 11:0 are AAAh, followed by 55h to bits 11:0 = 554h; the third write, to AAAh, selects: 90h identifier mode, A0h program arm, 80h erase arm, 20h bypass.
- R2: After program arm, the next accepted write of any value issues `cmd_op`=1 (program) with that write's address and data; `busy_n` is 0 from that edge until `op_done` is seen.
- R3: After 80h, a second unlock pair and then 10h to AAAh issue `cmd_op`=2 (whole erase) with `cmd_sectors` all ones.
- R4: After 80h and a second unlock pair, 30h to any address starts a sector gather window; each further 30h write adds its sector, where sector index = address bits 19:17. When TIMEOUT_CYC cycles pass with no write, `cmd_op`=3 issues, and `cmd_sectors` has a 1 for each gathered sector.
- R5: B0h during a sector erase issues `cmd_op`=4 (suspend) and sets `busy_n`=1; 30h while suspended issues `cmd_op`=5 (resume) and sets `busy_n`=0. B0h during a program or whole erase has no effect.
- R6: When no operation is in progress, F0h returns to read-array mode, and F0h is the only write that leaves identifier mode.
- R7: A write that does not match the expected step returns the decoder to read-array mode, and so does a gap of TIMEOUT_CYC cycles between writes of an unfinished sequence.
- R8: In bypass mode, A0h followed by a data write issues a program without unlock writes, and the decoder returns to bypass when done; 90h followed by 00h, or F0h, leaves bypass.
- R9: `id_sel`=1 only in identifier mode; there, `rd_addr` bits 7:0 = 04h give `id_data` 01h if `prot_mask` bit (rd_addr bits 19:17) is set and 00h otherwise; 00h gives MFR_CODE and 02h gives DEV_CODE.
- R10: A command record is held with stable fields while `cmd_ready` is low, and `wr_ready` is low until it is taken.
- R11: Reset (`rst_n` low) aborts any operation: afterwards `busy_n`=1, `cmd_valid`=0 and `id_sel`=0.
- R12: Writes during a program or erase in progress are ignored, apart from the suspend byte of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, aborts operations |
| wr_valid | input | 1 | Host write offered |
| wr_ready | output | 1 | Decoder can take a write |
| wr_addr | input | 20 | Write address |
| wr_data | input | 16 | Write data; bits 7:0 carry command bytes |
| rd_addr | input | 20 | Read address for identifier data |
| id_sel | output | 1 | Reads return `id_data` instead of array data |
| id_data | output | 8 | Identifier/protection read value |
| prot_mask | input | 8 | Per-sector protection flags |
| cmd_valid | output | 1 | Command record offered |
| cmd_ready | input | 1 | Engine takes the record |
| cmd_op | output | 3 | 1 program, 2 whole erase, 3 sector erase, 4 suspend, 5 resume |
| cmd_addr | output | 20 | Program address (0 for other ops) |
| cmd_data | output | 16 | Program data (0 for other ops) |
| cmd_sectors | output | 8 | Sector set for erases |
| op_done | input | 1 | Engine finished the operation |
| busy_n | output | 1 | 0 while program or erase runs |

## Verification
On every cycle the assertions check four things. A stalled command record keeps all its fields. A falling `busy_n` always comes with a program, erase or resume record. A suspend record only follows a running sector erase. Every sector flagged to the gather set appears in it on the next cycle. The bench scenarios must show the rest, since each needs a full write sequence and a known expected result: which byte sequences decode to which command, the gather window and the gap abort at their cycle counts, bypass entry and exit, the identifier values, and the fact that writes during a busy operation are ignored.

// File: rtl/fcsd_pkg.sv
package fcsd_pkg;
  typedef enum logic [4:0] {
    S_READ, S_UNL1, S_UNL2, S_ID, S_PGM_ARM,
    S_ERS_U0, S_ERS_U1, S_ERS_U2, S_SE_WIN,
    S_BUSY_PGM, S_BUSY_BPGM, S_BUSY_CE, S_BUSY_SE, S_SUSP,
    S_BYP, S_BYP_ARM, S_BYP_EXIT
  } fcsd_state_e;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0, OP_PROG = 3'd1, OP_CHIP = 3'd2,
    OP_SECT = 3'd3, OP_SUSP = 3'd4, OP_RESM = 3'd5
  } fcsd_op_e;

  localparam logic [11:0] UNL_ADDR_A = 12'hAAA;
  localparam logic [11:0] UNL_ADDR_B = 12'h554;
  localparam logic [7:0]  CB_KEY_A   = 8'hAA;
  localparam logic [7:0]  CB_KEY_B   = 8'h55;
  localparam logic [7:0]  CB_IDENT   = 8'h90;
  localparam logic [7:0]  CB_PROG    = 8'hA0;
  localparam logic [7:0]  CB_ERASE   = 8'h80;
  localparam logic [7:0]  CB_BYPASS  = 8'h20;
  localparam logic [7:0]  CB_WHOLE   = 8'h10;
  localparam logic [7:0]  CB_SECTOR  = 8'h30;
  localparam logic [7:0]  CB_PAUSE   = 8'hB0;
  localparam logic [7:0]  CB_ABORT   = 8'hF0;
  localparam logic [7:0]  CB_BEXIT   = 8'h00;
endpackage

// File: rtl/fcsd_gap_timer.sv
module fcsd_gap_timer #(
  parameter int unsigned TIMEOUT_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic expired
);
  localparam int unsigned CW = (TIMEOUT_CYC < 2) ? 1 : $clog2(TIMEOUT_CYC);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !run) cnt <= '0;
    else if (cnt != LAST)          cnt <= cnt + 1'b1;
  end

  assign expired = run && !restart && (cnt == LAST);

  // R7: counter never passes its limit
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // R7: an expiry is preceded by a quiet cycle
  a_r7_quiet_before_expire: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> !$past(restart));
endmodule

// File: rtl/fcsd_erase_set.sv
module fcsd_erase_set #(
  parameter int unsigned NSECT = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     add,
  input  logic [$clog2(NSECT)-1:0] idx,
  output logic [NSECT-1:0]         bits
);
  localparam int unsigned SW = $clog2(NSECT);

  for (genvar g = 0; g < NSECT; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n || clear)              bits[g] <= 1'b0;
      else if (add && idx == SW'(g))    bits[g] <= 1'b1;
    end
  end

  // R4: a flagged sector shows up in the set next cycle
  a_r4_add_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (add && !clear) |=> bits[$past(idx)]);
  // R4: without a clear the set only grows
  a_r4_grow_only: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ((bits & $past(bits)) == $past(bits)));
endmodule

// File: rtl/fcsd_id_read.sv
module fcsd_id_read #(
  parameter int unsigned NSECT    = 8,
  parameter logic [7:0]  MFR_CODE = 8'h20,
  parameter logic [7:0]  DEV_CODE = 8'hE4
) (
  input  logic [7:0]               rd_off,
  input  logic [$clog2(NSECT)-1:0] rd_sect,
  input  logic [NSECT-1:0]         prot_mask,
  output logic [7:0]               id_data
);
  always_comb begin
    unique case (rd_off)
      8'h00:   id_data = MFR_CODE;
      8'h02:   id_data = DEV_CODE;
      8'h04:   id_data = {7'd0, prot_mask[rd_sect]};
      default: id_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcsd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 20,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned NSECT       = 8,
  parameter int unsigned TIMEOUT_CYC = 64,
  parameter logic [7:0]  MFR_CODE    = 8'h20,
  parameter logic [7:0]  DEV_CODE    = 8'hE4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              id_sel,
  output logic [7:0]        id_data,
  input  logic [NSECT-1:0]  prot_mask,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [2:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic [NSECT-1:0]  cmd_sectors,
  input  logic              op_done,
  output logic              busy_n
);
  localparam int unsigned SW = $clog2(NSECT);

  fcsd_state_e state, nstate;
  fcsd_op_e    op_q, iop;
  logic        issue, set_clear, set_add, tmo, timed, wr_fire, in_busy;
  logic [7:0]  cb;
  logic [11:0] a12;
  logic        key_a, key_b, at_a;
  logic [NSECT-1:0] set_bits;
  logic [ADDR_W-1:0] rd_addr_unused;

  assign wr_ready = !cmd_valid;
  assign wr_fire  = wr_valid && wr_ready;
  assign cb       = wr_data[7:0];
  assign a12      = wr_addr[11:0];
  assign at_a     = (a12 == UNL_ADDR_A);
  assign key_a    = at_a && (cb == CB_KEY_A);
  assign key_b    = (a12 == UNL_ADDR_B) && (cb == CB_KEY_B);

  assign timed = state inside {S_UNL1, S_UNL2, S_PGM_ARM, S_ERS_U0, S_ERS_U1,
                               S_ERS_U2, S_SE_WIN, S_BYP_ARM, S_BYP_EXIT};
  assign in_busy = state inside {S_BUSY_PGM, S_BUSY_BPGM, S_BUSY_CE, S_BUSY_SE};

  fcsd_gap_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(timed), .restart(wr_fire), .expired(tmo)
  );

  fcsd_erase_set #(.NSECT(NSECT)) u_set (
    .clk(clk), .rst_n(rst_n), .clear(set_clear), .add(set_add),
    .idx(wr_addr[ADDR_W-1 -: SW]), .bits(set_bits)
  );

  fcsd_id_read #(.NSECT(NSECT), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
    .rd_off(rd_addr[7:0]), .rd_sect(rd_addr[ADDR_W-1 -: SW]),
    .prot_mask(prot_mask), .id_data(id_data)
  );
  assign rd_addr_unused = rd_addr;

  always_comb begin
    nstate    = state;
    issue     = 1'b0;
    iop       = OP_NONE;
    set_clear = 1'b0;
    set_add   = 1'b0;
    if (tmo) begin
      if (state == S_SE_WIN) begin
        issue = 1'b1; iop = OP_SECT; nstate = S_BUSY_SE;
      end else if (state inside {S_BYP_ARM, S_BYP_EXIT}) begin
        nstate = S_BYP;
      end else begin
        nstate = S_READ;
      end
    end else if (in_busy && op_done) begin
      nstate = (state == S_BUSY_BPGM) ? S_BYP : S_READ;
    end else if (wr_fire) begin
      unique case (state)
        S_READ:   if (key_a) nstate = S_UNL1;
        S_UNL1:   nstate = key_b ? S_UNL2 : S_READ;
        S_UNL2: begin
          nstate = S_READ;
          if (at_a) begin
            unique case (cb)
              CB_IDENT:  nstate = S_ID;
              CB_PROG:   nstate = S_PGM_ARM;
              CB_ERASE:  begin nstate = S_ERS_U0; set_clear = 1'b1; end
              CB_BYPASS: nstate = S_BYP;
              default:   nstate = S_READ;
            endcase
          end
        end
        S_ID:     if (cb == CB_ABORT) nstate = S_READ;
        S_PGM_ARM: begin issue = 1'b1; iop = OP_PROG; nstate = S_BUSY_PGM; end
        S_ERS_U0: nstate = key_a ? S_ERS_U1 : S_READ;
        S_ERS_U1: nstate = key_b ? S_ERS_U2 : S_READ;
        S_ERS_U2: begin
          if (at_a && cb == CB_WHOLE) begin
            issue = 1'b1; iop = OP_CHIP; nstate = S_BUSY_CE;
          end else if (cb == CB_SECTOR) begin
            set_add = 1'b1; nstate = S_SE_WIN;
          end else begin
            nstate = S_READ;
          end
        end
        S_SE_WIN: begin
          if (cb == CB_SECTOR) set_add = 1'b1;
          else                 nstate = S_READ;
        end
        S_BUSY_SE: if (cb == CB_PAUSE) begin
          issue = 1'b1; iop = OP_SUSP; nstate = S_SUSP;
        end
        S_SUSP: if (cb == CB_SECTOR) begin
          issue = 1'b1; iop = OP_RESM; nstate = S_BUSY_SE;
        end
        S_BYP: begin
          if (cb == CB_PROG)       nstate = S_BYP_ARM;
          else if (cb == CB_IDENT) nstate = S_BYP_EXIT;
          else if (cb == CB_ABORT) nstate = S_READ;
        end
        S_BYP_ARM: begin issue = 1'b1; iop = OP_PROG; nstate = S_BUSY_BPGM; end
        S_BYP_EXIT: nstate = (cb == CB_BEXIT) ? S_READ : S_BYP;
        default: nstate = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_READ;
    else        state <= nstate;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid   <= 1'b0;
      op_q        <= OP_NONE;
      cmd_addr    <= '0;
      cmd_data    <= '0;
      cmd_sectors <= '0;
    end else if (issue) begin
      cmd_valid   <= 1'b1;
      op_q        <= iop;
      cmd_addr    <= (iop == OP_PROG) ? wr_addr : '0;
      cmd_data    <= (iop == OP_PROG) ? wr_data : '0;
      unique case (iop)
        OP_CHIP: cmd_sectors <= '1;
        OP_SECT: cmd_sectors <= set_bits;
        default: cmd_sectors <= '0;
      endcase
    end else if (cmd_ready) begin
      cmd_valid <= 1'b0;
    end
  end

  assign cmd_op = op_q;
  assign busy_n = !in_busy;
  assign id_sel = (state == S_ID);

  // R10: a stalled record keeps every field
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_addr)
                                   && $stable(cmd_data) && $stable(cmd_sectors)));
  // R2: busy only starts together with a program, erase or resume record
  a_r2_busy_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> (cmd_valid && cmd_op inside {3'd1, 3'd2, 3'd3, 3'd5}));
  // R5: suspend only follows a running sector erase
  a_r5_suspend_origin: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cmd_valid) && cmd_op == 3'd4) |-> ($past(state) == S_BUSY_SE));
  // R3: a whole erase names every sector
  a_r3_whole_all: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd2) |-> (&cmd_sectors));
  // R11: reset leaves the block idle
  a_r11_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (busy_n && !cmd_valid && !id_sel));
endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;
  localparam int AW = 20;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic id_sel;
  logic [7:0] id_data;
  logic [7:0] prot_mask = 8'b0010_0000;
  logic cmd_valid;
  logic cmd_ready = 1'b1;
  logic [2:0] cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;
  logic [7:0] cmd_sectors;
  logic op_done = 1'b0;
  logic busy_n;

  int nchk = 0, nfail = 0, ncmd = 0;
  logic [2:0] l_op;
  logic [AW-1:0] l_addr;
  logic [DW-1:0] l_data;
  logic [7:0] l_sec;
  bit ended = 0;

  always #4 clk = ~clk;

  flash_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .id_sel(id_sel),
    .id_data(id_data), .prot_mask(prot_mask), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_sectors(cmd_sectors), .op_done(op_done),
    .busy_n(busy_n)
  );

  always @(posedge clk) begin
    if (rst_n && cmd_valid && cmd_ready) begin
      ncmd++;
      l_op = cmd_op; l_addr = cmd_addr; l_data = cmd_data; l_sec = cmd_sectors;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic unlock();
    wr(20'h00AAA, 16'h00AA);
    wr(20'h00554, 16'h0055);
  endtask

  task automatic done_pulse();
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; step(3); rst_n = 1'b1; step(1);
    chk("R11 reset busy_n", busy_n, 1);
    chk("R11 reset cmd_valid", cmd_valid, 0);
    chk("R11 reset id_sel", id_sel, 0);
    chk("R10 reset wr_ready", wr_ready, 1);
  endtask

  task automatic t_program();
    int n0 = ncmd;
    unlock(); wr(20'h00AAA, 16'h00A0); wr(20'h31234, 16'hBEEF); step(1);
    chk("R2 program count", ncmd, n0 + 1);
    chk("R2 program op", l_op, 1);
    chk("R2 program addr", l_addr, 20'h31234);
    chk("R2 program data", l_data, 16'hBEEF);
    chk("R2 busy during program", busy_n, 0);
    done_pulse();
    chk("R2 ready after done", busy_n, 1);
  endtask

  task automatic t_busy_ignore();
    int n0 = ncmd;
    unlock(); wr(20'h00AAA, 16'h00A0); wr(20'h00010, 16'h0F0F); step(1);
    unlock(); wr(20'h00AAA, 16'h0090); wr(20'h00000, 16'h00B0); step(2);
    chk("R12 no extra cmd while busy", ncmd, n0 + 1);
    chk("R5 B0 in program ignored", busy_n, 0);
    chk("R12 ident not entered while busy", id_sel, 0);
    done_pulse();
    chk("R12 read mode after done", id_sel, 0);
  endtask

  task automatic t_chip_erase();
    int n0 = ncmd;
    unlock(); wr(20'h00AAA, 16'h0080); unlock(); wr(20'h00AAA, 16'h0010); step(1);
    chk("R3 whole erase op", l_op, 2);
    chk("R3 whole erase sectors", l_sec, 8'hFF);
    wr(20'h00000, 16'h00B0); step(1);
    chk("R5 B0 in whole erase ignored", ncmd, n0 + 1);
    chk("R5 still busy in whole erase", busy_n, 0);
    done_pulse();
    chk("R3 ready after erase", busy_n, 1);
  endtask

  task automatic t_sector_erase();
    int n0 = ncmd;
    unlock(); wr(20'h00AAA, 16'h0080); unlock();
    wr(20'h20000, 16'h0030); step(20);
    wr(20'hA0000, 16'h0030); step(30);
    chk("R4 window still open", ncmd, n0);
    chk("R4 not busy in window", busy_n, 1);
    step(45);
    chk("R4 sector erase issued", ncmd, n0 + 1);
    chk("R4 sector op", l_op, 3);
    chk("R4 gathered sectors", l_sec, 8'h22);
    chk("R4 busy in sector erase", busy_n, 0);
    wr(20'h00000, 16'h00B0); step(1);
    chk("R5 suspend op", l_op, 4);
    chk("R5 ready while suspended", busy_n, 1);
    done_pulse();
    chk("R5 done ignored while suspended", busy_n, 1);
    wr(20'h00000, 16'h0030); step(1);
    chk("R5 resume op", l_op, 5);
    chk("R5 busy after resume", busy_n, 0);
    done_pulse();
    chk("R5 ready after sector erase", busy_n, 1);
  endtask

  task automatic t_id_read();
    unlock(); wr(20'h00AAA, 16'h0090); step(1);
    chk("R1 ident entered", id_sel, 1);
    rd_addr = 20'hA0004; step(1);
    chk("R9 protected sector reads 01", id_data, 8'h01);
    rd_addr = 20'h40004; step(1);
    chk("R9 open sector reads 00", id_data, 8'h00);
    rd_addr = 20'h00000; step(1);
    chk("R9 maker code", id_data, 8'h20);
    rd_addr = 20'h00002; step(1);
    chk("R9 device code", id_data, 8'hE4);
    wr(20'h00000, 16'h00AA); wr(20'h00000, 16'h0055); step(1);
    chk("R6 other writes keep ident", id_sel, 1);
    wr(20'h00000, 16'h00F0); step(1);
    chk("R6 F0 leaves ident", id_sel, 0);
  endtask

  task automatic t_invalid();
    int n0 = ncmd;
    unlock(); wr(20'h00AAA, 16'h0077); wr(20'h00123, 16'h4444); step(1);
    chk("R7 bad command byte aborts", ncmd, n0);
    wr(20'h00AAA, 16'h00AA); wr(20'h00555, 16'h0055); wr(20'h00AAA, 16'h0090); step(1);
    chk("R1 bad unlock address aborts", id_sel, 0);
    unlock(); wr(20'h00AAA, 16'h0080); wr(20'h00AAA, 16'h00AA);
    wr(20'h00554, 16'h0055); wr(20'h00AAA, 16'h0077); step(1);
    chk("R7 bad erase byte aborts", busy_n, 1);
  endtask

  task automatic t_timeout();
    wr(20'h00AAA, 16'h00AA); step(70);
    wr(20'h00554, 16'h0055); wr(20'h00AAA, 16'h0090); step(1);
    chk("R7 gap timeout aborts", id_sel, 0);
    wr(20'h00000, 16'h00F0); step(1);
  endtask

  task automatic t_bypass();
    int n0 = ncmd;
    unlock(); wr(20'h00AAA, 16'h0020);
    wr(20'h00000, 16'h00A0); wr(20'h11111, 16'h1234); step(1);
    chk("R8 bypass program op", l_op, 1);
    chk("R8 bypass program data", l_data, 16'h1234);
    done_pulse();
    wr(20'h00000, 16'h00A0); wr(20'h22222, 16'h5678); step(1);
    chk("R8 second bypass program", ncmd, n0 + 2);
    chk("R8 second bypass addr", l_addr, 20'h22222);
    done_pulse();
    wr(20'h00000, 16'h0090); wr(20'h00000, 16'h0000);
    wr(20'h00000, 16'h00A0); wr(20'h33333, 16'h9999); step(1);
    chk("R8 exit bypass", ncmd, n0 + 2);
    chk("R8 not busy after exit", busy_n, 1);
  endtask

  task automatic t_backpressure();
    int n0 = ncmd;
    cmd_ready = 1'b0;
    unlock(); wr(20'h00AAA, 16'h00A0); wr(20'h00456, 16'h1357); step(3);
    chk("R10 record held", cmd_valid, 1);
    chk("R10 writes stalled", wr_ready, 0);
    chk("R10 held op", cmd_op, 1);
    chk("R10 held data", cmd_data, 16'h1357);
    chk("R10 not taken yet", ncmd, n0);
    cmd_ready = 1'b1; step(1);
    chk("R10 record taken", ncmd, n0 + 1);
    chk("R10 valid drops", cmd_valid, 0);
    done_pulse();
  endtask

  task automatic t_reset_abort();
    unlock(); wr(20'h00AAA, 16'h00A0); wr(20'h00100, 16'h0001); step(1);
    chk("R11 busy before abort", busy_n, 0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; step(1);
    chk("R11 abort clears busy", busy_n, 1);
    chk("R11 abort clears cmd", cmd_valid, 0);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    t_reset();
    t_program();
    t_busy_ignore();
    t_chip_erase();
    t_sector_erase();
    t_id_read();
    t_invalid();
    t_timeout();
    t_bypass();
    t_backpressure();
    t_reset_abort();
    step(2);
    finish_run();
  end
endmodule